// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block is the byte-serial transmit engine of an Ethernet MAC. It draws frame bytes from a transmit FIFO through a simple read port. That port consists of a data byte, a last-byte marker, a fill level and a pop strobe. The block drives a byte-wide transmit stream with a transmit-enable qualifier. Each frame goes out as a preamble, a start delimiter, the frame bytes, any zero padding and then the frame check sequence. Padding and the frame check sequence can each be turned off with a control input.

The block does not begin sending until software has enabled transmission and the FIFO holds a minimum number of bytes. If the line reports a collision, the sequencer sends a short all-ones jam and gives up the frame. If the FIFO reports a parity fault, or runs dry in the middle of a frame, the frame is cut off at once. Each way a frame can end raises its own one-cycle status pulse. A successful frame can also raise an interrupt pulse.

Top module: `eth_tx_sequencer`

## Requirements
- R1: `tx_en` stays low while `tx_enable` is 0 or `fifo_level` is below 8. When both hold in idle, the sequencer starts, and the first byte appears on `txd` with `tx_en` high two clock edges after the start condition is sampled.
- R2: Every frame opens with seven bytes of 0x55 and then one byte of 0xD5, with `tx_en` held high without a gap until the frame ends.
- R3: After the delimiter, FIFO bytes are sent in FIFO order, one `fifo_pop` per byte sent. The byte that has `fifo_eof` high is the last FIFO byte of the frame.
- R4: If the frame is shorter than the minimum, 0x00 bytes are appended. The minimum is 60 bytes when the check sequence is appended and 64 bytes when `crc_disable` is 1. When `pad_disable` is 1, no pad byte is sent.
- R5: Unless `crc_disable` is 1, four check bytes follow the data and padding. They hold the complement of the reflected CRC-32, with polynomial 0x04C11DB7 and an all-ones start value, sent least significant byte first. The CRC covers the frame bytes and the pad bytes, and does not cover the preamble or the delimiter.
- R6: A collision seen during the preamble lets the preamble and delimiter finish. It is then followed by four 0xFF bytes. A collision seen later replaces the byte about to be sent and everything after it with four 0xFF bytes. After the jam, `tx_en` falls and `collided` pulses for one cycle, together with the last jam byte.
- R7: A `parity_halt` seen while a frame is active stops output, so `tx_en` is low after the next edge. `aborted` pulses and the sequencer returns to idle.
- R8: If `fifo_level` is 0 when a frame byte is due, the frame is aborted in the same way as in R7, and no pop is issued.
- R9: A frame that finishes normally raises `pkt_sent` for exactly one cycle, in the cycle its last byte is on `txd`. `irq` pulses with it only when `irq_enable` is 1. At most one of `pkt_sent`, `collided` and `aborted` is high in any cycle.
- R10: In idle, `collision` and `parity_halt` have no effect: no byte is sent and no status pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmission allowed |
| pad_disable | input | 1 | Suppress zero padding |
| crc_disable | input | 1 | Suppress check sequence |
| irq_enable | input | 1 | Allow the interrupt pulse on a good frame |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_eof | input | 1 | Head byte is the last of the frame |
| fifo_level | input | LVL_W | Number of bytes held in the FIFO |
| fifo_pop | output | 1 | Consume the head byte at this edge |
| collision | input | 1 | Collision reported by the line |
| parity_halt | input | 1 | FIFO parity fault, stop the frame |
| txd | output | 8 | Transmit byte |
| tx_en | output | 1 | Transmit byte valid |
| pkt_sent | output | 1 | One-cycle pulse, frame sent |
| irq | output | 1 | One-cycle interrupt pulse, frame sent |
| collided | output | 1 | One-cycle pulse, frame ended by jam |
| aborted | output | 1 | One-cycle pulse, frame cut by halt or underrun |

## Verification
The bench sweeps frame lengths across the pad boundary with every combination of the pad and check-sequence switches. A design that padded to 64 with the check sequence on, or padded when told not to, shows up as wrong lengths, and one that let the preamble into the CRC produces a wrong check sequence. Collisions are placed both inside the preamble and inside the data. A design that cut the preamble short, or sent the wrong number of jam bytes, emits a stream of the wrong shape. The directed cases are a start with exactly seven bytes buffered, halts and collisions applied in idle, a mid-frame parity halt and a FIFO that runs dry; each of these would leave extra bytes on the line or the wrong status pulse.

// File: rtl/eth_tx_sequencer.sv
module eth_tx_sequencer #(
  parameter int LVL_W       = 8,
  parameter int START_LEVEL = 8,
  parameter int PRE_LEN     = 8,
  parameter int JAM_LEN     = 4,
  parameter int MIN_FRAME   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             pad_disable,
  input  logic             crc_disable,
  input  logic             irq_enable,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_eof,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             fifo_pop,
  input  logic             collision,
  input  logic             parity_halt,
  output logic [7:0]       txd,
  output logic             tx_en,
  output logic             pkt_sent,
  output logic             irq,
  output logic             collided,
  output logic             aborted
);
  localparam int IW      = $clog2(PRE_LEN);
  localparam int LW      = $clog2(MIN_FRAME + 1);
  localparam int FCS_LEN = 4;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_PAD, S_FCS, S_JAM} st_t;

  st_t         st, nst;
  logic [IW-1:0] cnt, ncnt;
  logic [LW-1:0] len;
  logic [31:0] crc_q;
  logic        coll_pend;
  logic        out_v, crc_en, done_ok, done_col, done_ab;
  logic [7:0]  out_b;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  wire          coll_now = collision | coll_pend;
  wire          busy     = st != S_IDLE;
  wire          underrun = (st == S_DATA) && !coll_now && (fifo_level == '0);
  wire          halt     = busy && (parity_halt || underrun);
  wire [LW-1:0] len_inc  = (len == '1) ? len : len + 1'b1;
  wire [LW-1:0] data_min = crc_disable ? LW'(MIN_FRAME) : LW'(MIN_FRAME - FCS_LEN);
  wire          need_pad = !pad_disable && (len_inc < data_min);
  wire [31:0]   fcs      = ~crc_q;
  wire          start    = tx_enable && (fifo_level >= LVL_W'(START_LEVEL));

  always_comb begin
    nst      = st;
    ncnt     = cnt;
    out_v    = 1'b0;
    out_b    = 8'h00;
    fifo_pop = 1'b0;
    crc_en   = 1'b0;
    done_ok  = 1'b0;
    done_col = 1'b0;
    done_ab  = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        nst  = S_PRE;
        ncnt = '0;
      end
      S_PRE: begin
        out_v = 1'b1;
        ncnt  = cnt + 1'b1;
        if (cnt == IW'(PRE_LEN - 1)) begin
          out_b = 8'hD5;
          ncnt  = '0;
          nst   = coll_now ? S_JAM : S_DATA;
        end else begin
          out_b = 8'h55;
        end
      end
      S_DATA, S_PAD, S_FCS: begin
        out_v = 1'b1;
        if (coll_now) begin
          out_b = 8'hFF;
          nst   = S_JAM;
          ncnt  = IW'(1);
        end else if (st == S_FCS) begin
          out_b = fcs[{cnt[1:0], 3'b000} +: 8];
          ncnt  = cnt + 1'b1;
          if (cnt == IW'(FCS_LEN - 1)) begin
            nst     = S_IDLE;
            done_ok = 1'b1;
          end
        end else begin
          out_b    = (st == S_DATA) ? fifo_data : 8'h00;
          fifo_pop = st == S_DATA;
          crc_en   = 1'b1;
          if (st == S_PAD || fifo_eof) begin
            ncnt = '0;
            if (need_pad)         nst = S_PAD;
            else if (crc_disable) begin nst = S_IDLE; done_ok = 1'b1; end
            else                  nst = S_FCS;
          end
        end
      end
      S_JAM: begin
        out_v = 1'b1;
        out_b = 8'hFF;
        ncnt  = cnt + 1'b1;
        if (cnt == IW'(JAM_LEN - 1)) begin
          nst      = S_IDLE;
          done_col = 1'b1;
        end
      end
      default: nst = S_IDLE;
    endcase
    if (halt) begin
      nst      = S_IDLE;
      out_v    = 1'b0;
      fifo_pop = 1'b0;
      crc_en   = 1'b0;
      done_ok  = 1'b0;
      done_col = 1'b0;
      done_ab  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      len       <= '0;
      crc_q     <= '1;
      coll_pend <= 1'b0;
      txd       <= 8'h00;
      tx_en     <= 1'b0;
      pkt_sent  <= 1'b0;
      irq       <= 1'b0;
      collided  <= 1'b0;
      aborted   <= 1'b0;
    end else begin
      st        <= nst;
      cnt       <= ncnt;
      len       <= !busy ? '0 : (crc_en ? len_inc : len);
      crc_q     <= !busy ? '1 : (crc_en ? crc_byte(crc_q, out_b) : crc_q);
      coll_pend <= (nst == S_IDLE) ? 1'b0 : (busy && (coll_pend | collision));
      txd       <= out_v ? out_b : 8'h00;
      tx_en     <= out_v;
      pkt_sent  <= done_ok;
      irq       <= done_ok & irq_enable;
      collided  <= done_col;
      aborted   <= done_ab;
    end
  end
endmodule

// File: rtl/eth_tx_sequencer_chk.sv
module eth_tx_sequencer_chk #(
  parameter int LVL_W       = 8,
  parameter int START_LEVEL = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_enable,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_pop,
  input logic             parity_halt,
  input logic [7:0]       txd,
  input logic             tx_en,
  input logic             pkt_sent,
  input logic             irq,
  input logic             collided,
  input logic             aborted
);
  a_r1_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(tx_enable, 2) && ($past(fifo_level, 2) >= LVL_W'(START_LEVEL))));

  a_r2_opens_with_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == 8'h55));

  a_r3_pop_means_send: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> tx_en);

  a_r6_jam_tail: assert property (@(posedge clk) disable iff (!rst_n)
    collided |-> (tx_en && txd == 8'hFF));

  a_r7_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && parity_halt) |=> !tx_en);

  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_level != '0));

  a_r9_irq_with_sent: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pkt_sent);

  a_r9_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_sent, collided, aborted}));
endmodule

bind eth_tx_sequencer eth_tx_sequencer_chk #(.LVL_W(LVL_W), .START_LEVEL(START_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .fifo_level(fifo_level),
  .fifo_pop(fifo_pop), .parity_halt(parity_halt), .txd(txd), .tx_en(tx_en),
  .pkt_sent(pkt_sent), .irq(irq), .collided(collided), .aborted(aborted)
);

// File: tb/eth_tx_sequencer_bench.sv
module eth_tx_sequencer_bench;
  localparam int CLK_NS = 10;
  localparam int LVL_W  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_enable = 0, pad_disable = 0, crc_disable = 0, irq_enable = 0;
  logic [7:0] fifo_data = 0;
  logic fifo_eof = 0;
  logic [LVL_W-1:0] fifo_level = 0;
  logic fifo_pop, collision = 0, parity_halt = 0;
  logic [7:0] txd;
  logic tx_en, pkt_sent, irq, collided, aborted;

  always #(CLK_NS/2) clk = ~clk;

  eth_tx_sequencer u_eth_tx_sequencer (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .pad_disable(pad_disable),
    .crc_disable(crc_disable), .irq_enable(irq_enable), .fifo_data(fifo_data),
    .fifo_eof(fifo_eof), .fifo_level(fifo_level), .fifo_pop(fifo_pop),
    .collision(collision), .parity_halt(parity_halt), .txd(txd), .tx_en(tx_en),
    .pkt_sent(pkt_sent), .irq(irq), .collided(collided), .aborted(aborted)
  );

  int checks = 0, errors = 0;
  byte unsigned q[$];
  byte unsigned rec[$];
  bit   has_eof = 0, last_pop = 0, inj_done = 0;
  int   mode = 0, inj_at = 0;
  int   n_sent = 0, n_irq = 0, n_coll = 0, n_abort = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input byte unsigned b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[i]) begin
      c = c ^ {24'h0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic drive_fifo();
    fifo_level = (q.size() > 255) ? 8'd255 : LVL_W'(q.size());
    fifo_data  = (q.size() > 0) ? q[0] : 8'h00;
    fifo_eof   = has_eof && (q.size() == 1);
  endtask

  task automatic step();
    @(negedge clk);
    if (tx_en) rec.push_back(txd);
    n_sent += int'(pkt_sent); n_irq += int'(irq);
    n_coll += int'(collided); n_abort += int'(aborted);
    if (last_pop && q.size() > 0) void'(q.pop_front());
    if (pkt_sent || collided || aborted) begin
      tx_enable = 0;
      q.delete();
    end
    collision   = (mode == 1) && !inj_done && (rec.size() == inj_at);
    parity_halt = (mode == 2) && !inj_done && (rec.size() == inj_at);
    if (collision || parity_halt) inj_done = 1;
    drive_fifo();
    #1 last_pop = fifo_pop;
  endtask

  // mode: 0 normal, 1 collision after inj_at bytes, 2 halt after inj_at bytes, 3 FIFO runs dry
  task automatic run_frame(input int len, input bit pd, input bit cd, input bit ie,
                           input int md, input int at);
    byte unsigned pay[$];
    byte unsigned exp[$];
    byte unsigned body[$];
    logic [31:0] f;
    int mn;
    pay.delete(); exp.delete(); rec.delete(); q.delete();
    for (int i = 0; i < len; i++) pay.push_back(byte'($urandom_range(0, 255)));
    for (int i = 0; i < 7; i++) exp.push_back(8'h55);
    exp.push_back(8'hD5);
    body = pay;
    mn = cd ? 64 : 60;
    if (md != 3) begin
      if (!pd) while (body.size() < mn) body.push_back(8'h00);
      foreach (body[i]) exp.push_back(body[i]);
      if (!cd) begin
        f = ref_crc(body);
        for (int k = 0; k < 4; k++) exp.push_back(f[8*k +: 8]);
      end
    end else begin
      foreach (pay[i]) exp.push_back(pay[i]);
    end
    if (md == 1) begin
      if (at < 8) while (exp.size() > 8) void'(exp.pop_back());
      else        while (exp.size() > at) void'(exp.pop_back());
      for (int k = 0; k < 4; k++) exp.push_back(8'hFF);
    end else if (md == 2) begin
      while (exp.size() > at) void'(exp.pop_back());
    end
    n_sent = 0; n_irq = 0; n_coll = 0; n_abort = 0;
    mode = md; inj_at = at; inj_done = 0;
    pad_disable = pd; crc_disable = cd; irq_enable = ie;
    q = pay; has_eof = (md != 3);
    tx_enable = 1;
    for (int s = 0; s < exp.size() + 12; s++) step();
    tx_enable = 0; mode = 0;
    check(rec.size() == exp.size(), (md == 1) ? "R6 length" : (md == 2) ? "R7 length" :
          (md == 3) ? "R8 length" : (pd ? "R4 length" : "R4/R5 length"), rec.size(), exp.size());
    if (rec.size() == exp.size()) begin
      int bad = -1;
      foreach (exp[i]) if (bad < 0 && rec[i] != exp[i]) bad = i;
      check(bad < 0, (bad >= 0 && bad < 8) ? "R2 preamble" : "R3/R5 content",
            (bad >= 0) ? int'(rec[bad]) : 0, (bad >= 0) ? int'(exp[bad]) : 0);
    end
    check(n_sent == ((md == 0) ? 1 : 0), "R9 pkt_sent", n_sent, (md == 0) ? 1 : 0);
    check(n_irq == ((md == 0 && ie) ? 1 : 0), "R9 irq", n_irq, (md == 0 && ie) ? 1 : 0);
    check(n_coll == ((md == 1) ? 1 : 0), "R6 collided", n_coll, (md == 1) ? 1 : 0);
    check(n_abort == ((md == 2 || md == 3) ? 1 : 0), "R7/R8 aborted", n_abort,
          (md == 2 || md == 3) ? 1 : 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check(!tx_en && txd == 8'h00, "reset tx_en/txd", int'(tx_en), 0);
    check(!pkt_sent && !irq && !collided && !aborted, "reset pulses",
          int'({pkt_sent, irq, collided, aborted}), 0);

    // R10: collision and halt in idle are ignored
    rec.delete(); n_sent = 0; n_coll = 0; n_abort = 0;
    for (int s = 0; s < 6; s++) begin
      step();
      collision = 1; parity_halt = 1;
    end
    step(); collision = 0; parity_halt = 0;
    repeat (3) step();
    check(rec.size() == 0, "R10 idle output", rec.size(), 0);
    check(n_coll + n_abort + n_sent == 0, "R10 idle pulses", n_coll + n_abort + n_sent, 0);

    // R1: seven bytes buffered never start, eighth starts
    rec.delete(); n_sent = 0;
    for (int i = 0; i < 7; i++) q.push_back(byte'(i + 1));
    has_eof = 0; tx_enable = 1;
    repeat (20) step();
    check(rec.size() == 0, "R1 below threshold", rec.size(), 0);
    q.push_back(8'h08); has_eof = 1;
    step(); step();
    check(rec.size() == 0, "R1 latency low", rec.size(), 0);
    step();
    check(rec.size() == 1 && rec[0] == 8'h55, "R1 start", rec.size(), 1);
    repeat (90) step();
    check(n_sent == 1 && rec.size() == 72, "R1 frame done", rec.size(), 72);
    tx_enable = 0; q.delete();

    // R1: enable low with a full FIFO
    rec.delete();
    for (int i = 0; i < 20; i++) q.push_back(8'hAA);
    has_eof = 1;
    repeat (15) step();
    check(rec.size() == 0, "R1 enable low", rec.size(), 0);
    q.delete();

    // directed boundaries for R4 and R5
    run_frame(60, 0, 0, 1, 0, 0);
    run_frame(59, 0, 0, 1, 0, 0);
    run_frame(63, 0, 1, 0, 0, 0);
    run_frame(64, 0, 1, 1, 0, 0);
    run_frame(10, 1, 0, 1, 0, 0);
    run_frame(10, 1, 1, 0, 0, 0);
    run_frame(12, 0, 1, 1, 0, 0);
    // R6 collision in preamble and in data, R7 halt, R8 underrun
    run_frame(30, 0, 0, 0, 1, 3);
    run_frame(30, 0, 0, 0, 1, 7);
    run_frame(30, 0, 0, 0, 1, 8);
    run_frame(30, 0, 0, 0, 1, 20);
    run_frame(40, 0, 0, 0, 2, 15);
    run_frame(40, 0, 0, 0, 2, 2);
    run_frame(14, 0, 0, 0, 3, 0);

    for (int t = 0; t < 40; t++) begin
      int len = $urandom_range(8, 100);
      int md  = (t % 4 == 3) ? int'($urandom_range(1, 2)) : 0;
      int at  = $urandom_range(1, 8 + len - 1);
      run_frame(len, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), md, at);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule